// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block connects a clocked request port to an external asynchronous static RAM of 32,768 bytes (15 address bits, 8 data bits). The RAM has three active-low strobes: chip select, write strobe and output enable. It also shares a single data bus for both directions. The host raises a request together with a direction flag, an address and, for stores, a byte. The controller drops its ready flag and runs one memory cycle. For a load, it then returns the fetched byte with a one-cycle valid pulse.

Each memory cycle has three phases: an address setup phase, an active phase and a bus recovery phase. The length of each phase in clocks comes from the RAM's nanosecond limits and a clock period parameter. Every limit is divided by the period and rounded up, with a floor of one clock. The address only moves while both chip select and write strobe are high. Output enable stays high for the whole of every store. The controller's own data driver stays off through the recovery time after the RAM releases the bus.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is high, and whenever the controller is idle, the three strobes (`mem_ce_n`, `mem_we_n`, `mem_oe_n`) are all 1, `mem_dq_oe` is 0 and `ready` is 1.
- R2: A load (`req_wr`=0) holds `mem_ce_n` and `mem_oe_n` at 0 with `mem_we_n` at 1 for exactly RD_CYC clocks. RD_CYC is the largest of ceil(55 ns/period), ceil(55 ns/period) and ceil(30 ns/period). With a 10 ns period this is 6 clocks.
- R3: For a load, `rd_data` carries the byte stored at the requested address. `rd_valid` is high for exactly one clock, RD_CYC+2 clocks after the edge that accepts the request.
- R4: A store (`req_wr`=1) holds `mem_ce_n` and `mem_we_n` at 0 with `mem_oe_n` at 1 for exactly WR_CYC clocks, where WR_CYC is the largest of ceil(55/period), ceil(45/period), ceil(50/period) and ceil(25/period). With a 10 ns period this is 6 clocks. After the store, the RAM holds `req_wdata` at `req_addr`.
- R5: The store byte is on `mem_dq_out` with `mem_dq_oe` at 1 from the setup clock onward. It stays unchanged throughout the write strobe and for one clock after the strobe rises.
- R6: `mem_addr` changes only on an edge where `mem_ce_n` and `mem_we_n` are 1 both before and after that edge.
- R7: `ready` is 0 from the edge that accepts a request until the recovery phase ends. A request that arrives while `ready` is 0 starts no memory cycle and leaves the RAM contents unchanged.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After `mem_oe_n` rises, the driver stays off for at least TURN_CYC = ceil(20 ns/period) clocks, which is 2 clocks at 10 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, taken when ready is 1 |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Store byte |
| ready | output | 1 | Controller idle and able to accept |
| rd_data | output | 8 | Fetched byte |
| rd_valid | output | 1 | One-clock pulse marking rd_data |
| mem_addr | output | 15 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Byte for the bus driver |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 8 | Byte read back from the bus |

## Verification
Counting from the accepting edge, the strobes fall one clock later. At the default period, `rd_valid` rises RD_CYC+1 clocks after that, and `ready` returns after a further TURN_CYC clocks. The bench therefore expects `rd_valid` at the 8th and `ready` at the 10th falling edge after a request. Every output is sampled on falling clock edges, halfway between the register updates. Strobe pulse widths, address quiet times, driver overlap and the recovery gap are measured by a monitor that counts low-phase lengths on those same falling edges. The RAM model answers loads and commits stores from what it sees at those edges.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // nanoseconds to clocks, rounded up, never below one clock
  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_ACT   = 2'd2,
    SQ_TURN  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= bus_in;
    end
  end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 45,
  parameter int T_AW_NS       = 50,
  parameter int T_DW_NS       = 25,
  parameter int T_HZ_NS       = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned RD_CYC = max2(ns_to_clk(T_RC_NS, CLK_PERIOD_NS),
                                        max2(ns_to_clk(T_AA_NS, CLK_PERIOD_NS),
                                             ns_to_clk(T_OE_NS, CLK_PERIOD_NS)));
  localparam int unsigned WR_CYC = max2(max2(ns_to_clk(T_WC_NS, CLK_PERIOD_NS),
                                             ns_to_clk(T_WP_NS, CLK_PERIOD_NS)),
                                        max2(ns_to_clk(T_AW_NS, CLK_PERIOD_NS),
                                             ns_to_clk(T_DW_NS, CLK_PERIOD_NS)));
  localparam int unsigned TURN_CYC = ns_to_clk(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned LONGEST  = max2(max2(RD_CYC, WR_CYC), TURN_CYC);
  localparam int CNT_W = $clog2(LONGEST + 1);

  seq_state_t       state;
  logic             is_wr;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_done;
  logic             cap;

  // phase timer reload: active length on leaving setup, recovery length on leaving active
  always_comb begin
    t_load = 1'b0;
    t_val  = CNT_W'(TURN_CYC - 1);
    if (state == SQ_SETUP) begin
      t_load = 1'b1;
      t_val  = is_wr ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
    end else if (state == SQ_ACT && t_done) begin
      t_load = 1'b1;
    end
  end

  assign cap = (state == SQ_ACT) && t_done && !is_wr;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_done)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .capture  (cap),
    .bus_in   (mem_dq_in),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      is_wr      <= 1'b0;
      ready      <= 1'b1;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (req && ready) begin
            mem_addr <= req_addr;
            is_wr    <= req_wr;
            ready    <= 1'b0;
            state    <= SQ_SETUP;
            if (req_wr) begin
              mem_dq_out <= req_wdata;
              mem_dq_oe  <= 1'b1;
            end
          end
        end
        SQ_SETUP: begin
          mem_ce_n <= 1'b0;
          if (is_wr) mem_we_n <= 1'b0;
          else       mem_oe_n <= 1'b0;
          state <= SQ_ACT;
        end
        SQ_ACT: begin
          if (t_done) begin
            mem_ce_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            state    <= SQ_TURN;
          end
        end
        SQ_TURN: begin
          mem_dq_oe <= 1'b0;
          if (t_done) begin
            ready <= 1'b1;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r2_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  a_r5_data_steady: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe && $stable(mem_dq_out)));

  a_r5_data_hold: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_we_n) && !$past(rst)) |-> mem_dq_oe);

  a_r6_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mem_addr) && !$past(rst)) |->
      (mem_ce_n && mem_we_n && $past(mem_ce_n) && $past(mem_we_n)));

  a_r7_accept_on_req: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(req));

  a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  a_r8_release_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |=> !mem_dq_oe);
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .ready      (ready),
  .rd_valid   (rd_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_port_ctrl.sv
module sim_sram_port_ctrl;
  localparam int CLK_NS = 10;
  localparam int RD_N   = (55 + CLK_NS - 1) / CLK_NS;
  localparam int WR_N   = (55 + CLK_NS - 1) / CLK_NS;
  localparam int TURN_N = (20 + CLK_NS - 1) / CLK_NS;
  localparam int NVEC   = 11;

  // vector: [23] store, [22:8] address, [7:0] store byte or expected load byte
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 15'h0000, 8'hA5}, {1'b1, 15'h7FFF, 8'h5A}, {1'b1, 15'h1234, 8'h3C},
    {1'b1, 15'h0001, 8'hFF}, {1'b0, 15'h0000, 8'hA5}, {1'b0, 15'h7FFF, 8'h5A},
    {1'b0, 15'h1234, 8'h3C}, {1'b0, 15'h0001, 8'hFF}, {1'b1, 15'h1234, 8'h00},
    {1'b0, 15'h1234, 8'h00}, {1'b0, 15'h4000, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rd_data, mem_dq_out;
  logic [7:0]  mem_dq_in = '0;
  logic [14:0] mem_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sram_port_ctrl #(.CLK_PERIOD_NS(CLK_NS)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // RAM model and timing monitor, all on falling edges
  logic [7:0]  ram [int];
  int          ce_run = 0, we_run = 0, oe_run = 0;
  int          last_ce = 0, last_we = 0, last_oe = 0, ce_falls = 0;
  int          since_oe_rise = 1000, gap_at_drive = 1000;
  int          viol_r5 = 0, viol_r6 = 0, viol_r8 = 0;
  logic        p_wlow = 1'b0, p_ce_n = 1'b1, p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
  logic [7:0]  p_dq = '0;
  logic [14:0] p_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_wlow && !(!mem_ce_n && !mem_we_n)) ram[int'(p_addr)] = p_dq;
      if (!mem_we_n && (!mem_dq_oe || (p_wlow && mem_dq_out != p_dq))) viol_r5++;
      if (p_wlow && mem_we_n && (!mem_dq_oe || mem_dq_out != p_dq)) viol_r5++;
      if (mem_addr != p_addr && !(mem_ce_n && mem_we_n && p_ce_n && p_we_n)) viol_r6++;
      if (!mem_oe_n && mem_dq_oe) viol_r8++;
      if (mem_oe_n && !p_oe_n) since_oe_rise = 0;
      else if (since_oe_rise < 1000) since_oe_rise++;
      if (mem_dq_oe && !p_dq_oe) gap_at_drive = since_oe_rise;
      if (!mem_ce_n) begin
        if (p_ce_n) ce_falls++;
        ce_run++;
      end else if (ce_run > 0) begin last_ce = ce_run; ce_run = 0; end
      if (!mem_we_n) we_run++;
      else if (we_run > 0) begin last_we = we_run; we_run = 0; end
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin last_oe = oe_run; oe_run = 0; end
    end
    p_wlow  = !mem_ce_n && !mem_we_n;
    p_ce_n  = mem_ce_n;
    p_we_n  = mem_we_n;
    p_oe_n  = mem_oe_n;
    p_dq_oe = mem_dq_oe;
    p_dq    = mem_dq_out;
    p_addr  = mem_addr;
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'h00;
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one transaction; counts falling edges from the accepting edge
  task automatic txn(input bit wr, input logic [14:0] a, input logic [7:0] d,
                     output logic [7:0] got, output int vlat, output int vcnt, output int rlat);
    int c;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    c = 1; vlat = -1; vcnt = 0; got = '0;
    while (!ready && c < 100) begin
      if (rd_valid) begin
        vcnt++;
        if (vlat < 0) begin vlat = c; got = rd_data; end
      end
      @(negedge clk);
      c++;
    end
    rlat = c;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] got;
    int vlat, vcnt, rlat, falls0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && ready, "R1 reset state",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 5'b11101);
    rst = 1'b0;
    @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && ready, "R1 idle state",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 5'b11101);

    for (int i = 0; i < NVEC; i++) begin
      txn(VEC[i][23], VEC[i][22:8], VEC[i][7:0], got, vlat, vcnt, rlat);
      if (VEC[i][23]) begin
        check(last_we == WR_N, "R4 write strobe width", last_we, WR_N);
        check(last_ce == WR_N, "R4 select width in write", last_ce, WR_N);
        check(vcnt == 0, "R3 no valid on write", vcnt, 0);
        check(rlat == WR_N + TURN_N + 2, "R7 ready return after write", rlat, WR_N + TURN_N + 2);
      end else begin
        check(last_oe == RD_N && last_ce == RD_N, "R2 read strobe width", last_oe, RD_N);
        check(got == VEC[i][7:0], "R3 read data", got, VEC[i][7:0]);
        check(vlat == RD_N + 2, "R3 valid latency", vlat, RD_N + 2);
        check(vcnt == 1, "R3 valid single clock", vcnt, 1);
        check(rlat == RD_N + TURN_N + 2, "R7 ready return after read", rlat, RD_N + TURN_N + 2);
      end
    end

    // R4: store reaches the RAM model at both address ends
    check(ram.exists(0) && ram[0] == 8'hA5, "R4 stored byte low end", ram[0], 8'hA5);
    check(ram.exists(32767) && ram[32767] == 8'h5A, "R4 stored byte high end", ram[32767], 8'h5A);

    // R8: store right after a load keeps the driver off through recovery
    txn(1'b0, 15'h0001, 8'h00, got, vlat, vcnt, rlat);
    txn(1'b1, 15'h0002, 8'h77, got, vlat, vcnt, rlat);
    check(gap_at_drive >= TURN_N, "R8 recovery before drive", gap_at_drive, TURN_N);

    // R7: request while busy is ignored
    falls0 = ce_falls;
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = 15'h0003; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 15'h0002; req_wdata = 8'hEE;
    @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
    check(ce_falls - falls0 == 1, "R7 one cycle for busy request", ce_falls - falls0, 1);
    txn(1'b0, 15'h0002, 8'h00, got, vlat, vcnt, rlat);
    check(got == 8'h77, "R7 busy store ignored", got, 8'h77);

    // R5, R6, R8: monitor violation counts
    check(viol_r5 == 0, "R5 store data driven", viol_r5, 0);
    check(viol_r6 == 0, "R6 address quiet", viol_r6, 0);
    check(viol_r8 == 0, "R8 no bus contention", viol_r8, 0);

    // R1: reset in the middle of a store returns to idle
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = 15'h0005; req_wdata = 8'h42;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && ready, "R1 reset mid store",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 5'b11101);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    txn(1'b0, 15'h0000, 8'h00, got, vlat, vcnt, rlat);
    check(got == 8'hA5 && vlat == RD_N + 2, "R3 read after reset", got, 8'hA5);
    report();
  end
endmodule